// File: doc/BRIEF.md
# Programmable System Address Decoder

This block steers every host memory request to exactly one downstream target in the same cycle the request is presented. It combines four relocatable register windows, a legacy region below 1 MB that is split into a graphics range and attribute-controlled segments, a low-DRAM limit with a graphics carve-out directly beneath it, and a rejection path for requests at or above 4 GB. The result is a one-hot target vector plus a permission flag and an unsupported flag.

Software programs the routing through a narrow synchronous write port that addresses eight 32-bit configuration words. A write takes effect on the clock edge that captures it. The request path itself holds no state: a request sees the configuration that was in place before that edge. Data transfer, the memory controller and configuration-space contents are handled elsewhere.

Top module: `sys_addr_decoder`

## Requirements
- R1: A valid request whose 2-bit upper qualifier `req_hi` is nonzero (an access at or above 4 GB) selects abort. It raises `unsupported` and clears `perm_ok`. A zero qualifier never raises `unsupported`.
- R2: `tgt_sel` bit positions are 0 internal registers, 1 egress registers, 2 link registers, 3 configuration window, 4 DRAM, 5 graphics, 6 PCI Express port, 7 downstream link and 8 abort. With `req_valid` high exactly one bit is set. With it low, all outputs are zero.
- R3: Configuration words 0, 1 and 2 hold the base of the 16 KB internal-register window, the 4 KB egress window and the 4 KB link window. Bit 0 of each word enables its window. Base bits below the window size are ignored. A disabled window claims nothing.
- R4: Word 3 holds the configuration window: enable in bit 0 and size in bits [2:1] (0 = 64 MB, 1 = 128 MB, 2 or 3 = 256 MB). The base is taken aligned to the selected size.
- R5: Register windows win over every legacy and DRAM decode. Among overlapping enabled windows the order is internal, egress, link, configuration.
- R6: Word 7 holds 2-bit attributes for sixteen 16 KB segments starting at 0xC0000, with segment i in bits [2i+1:2i] (0 disabled, 1 read/write, 2 write-only, 3 read-only). A read of a write-only segment, or a write of a read-only segment, selects abort with `perm_ok` low. Every other request that selects abort also has `perm_ok` low.
- R7: A segment with the disabled attribute sends both reads and writes to the downstream link with `perm_ok` high.
- R8: Word 6 bits [1:0] steer the range 0xA0000 to 0xBFFFF: 0 to the PCI Express port, 1 or 3 to the downstream link, 2 to graphics.
- R9: Word 4 bits [31:20] give the low-DRAM limit in MB. A non-window request at or above 1 MB and at or above the limit goes to the downstream link and never to DRAM.
- R10: Word 5 bits [6:0] give the graphics carve-out in MB, clamped to 64. Requests at or above 1 MB that fall in the range [limit minus carve-out, limit) go to graphics. The lower bound stops at zero.
- R11: Addresses below 0xA0000, and addresses between 1 MB and the carve-out, go to DRAM with `perm_ok` high.
- R12: A configuration write changes routing from the next cycle on. Writes to word indices 8 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears all configuration words |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Configuration word index |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Request byte address |
| req_hi | input | 2 | Upper-address qualifier; nonzero means 4 GB or above |
| req_write | input | 1 | 1 = write, 0 = read |
| tgt_sel | output | 9 | One-hot target select |
| perm_ok | output | 1 | Access permitted |
| unsupported | output | 1 | Address beyond the 4 GB space |

## Verification
A configuration write and a request can fall in the same cycle. The request must then be routed by the old configuration, and the request in the following cycle by the new one. The bench provokes this by keeping a request asserted while it programs the limit, the carve-out, the windows and the segment attributes. In a long random phase it also issues configuration writes, to any of the sixteen indices, alongside requests to every region. Its behavioural model updates its shadow configuration on the same edge and is compared with the outputs on every clock, so any early or late use of a new word shows up as a mismatch.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;
   localparam int TGT_N  = 9;
   localparam int T_IREG = 0;
   localparam int T_EGR  = 1;
   localparam int T_LREG = 2;
   localparam int T_CFGW = 3;
   localparam int T_DRAM = 4;
   localparam int T_GFX  = 5;
   localparam int T_PEG  = 6;
   localparam int T_DSL  = 7;
   localparam int T_ABT  = 8;

   localparam int REG_N     = 8;
   localparam int REG_IREG  = 0;
   localparam int REG_EGR   = 1;
   localparam int REG_LREG  = 2;
   localparam int REG_CFGW  = 3;
   localparam int REG_LIMIT = 4;
   localparam int REG_GFX   = 5;
   localparam int REG_ROUTE = 6;
   localparam int REG_SEG   = 7;

   localparam int WIN_N  = 4;
   localparam int GFX_FW = 7;

   typedef logic [TGT_N-1:0] tgt_vec_t;

   typedef enum logic [1:0] {
      SEG_OFF = 2'd0,
      SEG_RW  = 2'd1,
      SEG_WO  = 2'd2,
      SEG_RO  = 2'd3
   } seg_attr_e;

   typedef enum logic [1:0] {
      LG_PEG  = 2'd0,
      LG_DSL  = 2'd1,
      LG_GFX  = 2'd2,
      LG_RSVD = 2'd3
   } leg_route_e;
endpackage

// File: rtl/addr_dec_cfg.sv
module addr_dec_cfg
   import addr_dec_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int IDX_W      = 4,
   parameter int SEG_N      = 16,
   parameter int GFX_MAX_MB = 64,
   parameter int MB_W       = ADDR_W - 20
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we,
   input  logic [IDX_W-1:0]              idx,
   input  logic [ADDR_W-1:0]             wdata,
   output logic [WIN_N-1:0][ADDR_W-1:0]  win_words,
   output logic [MB_W-1:0]               limit_mb,
   output logic [GFX_FW-1:0]             gfx_mb,
   output logic [1:0]                    route,
   output logic [2*SEG_N-1:0]            seg_attr
);
   localparam int SEG_BITS = 2 * SEG_N;

   if (2 * SEG_N > ADDR_W) begin : g_bad_seg
      $error("segment attributes do not fit one configuration word");
   end
   if ((1 << IDX_W) < REG_N) begin : g_bad_idx
      $error("index too narrow for configuration words");
   end
   if (GFX_MAX_MB >= (1 << GFX_FW)) begin : g_bad_gfx
      $error("carve-out clamp exceeds field range");
   end

   logic [REG_N-1:0][ADDR_W-1:0] regq;

   for (genvar g = 0; g < REG_N; g++) begin : g_reg
      logic [ADDR_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (we && (idx == IDX_W'(g))) begin
            q <= wdata;
         end
      end
      assign regq[g] = q;
   end

   for (genvar w = 0; w < WIN_N; w++) begin : g_win
      assign win_words[w] = regq[w];
   end

   logic [GFX_FW-1:0] gfx_raw;
   assign gfx_raw  = regq[REG_GFX][GFX_FW-1:0];
   assign gfx_mb   = (gfx_raw > GFX_FW'(GFX_MAX_MB)) ? GFX_FW'(GFX_MAX_MB) : gfx_raw;
   assign limit_mb = regq[REG_LIMIT][ADDR_W-1:20];
   assign route    = regq[REG_ROUTE][1:0];
   assign seg_attr = regq[REG_SEG][SEG_BITS-1:0];

   logic cfg_unused;
   if (SEG_BITS < ADDR_W) begin : g_seg_sink
      assign cfg_unused = ^{regq[REG_LIMIT][19:0], regq[REG_GFX][ADDR_W-1:GFX_FW],
                            regq[REG_ROUTE][ADDR_W-1:2], regq[REG_SEG][ADDR_W-1:SEG_BITS]};
   end else begin : g_seg_full
      assign cfg_unused = ^{regq[REG_LIMIT][19:0], regq[REG_GFX][ADDR_W-1:GFX_FW],
                            regq[REG_ROUTE][ADDR_W-1:2]};
   end
endmodule

// File: rtl/addr_dec_win.sv
module addr_dec_win #(
   parameter int ADDR_W    = 32,
   parameter int MIN_SHIFT = 12,
   parameter bit SEL_SIZES = 1'b0
)(
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] word,
   output logic              hit
);
   if (MIN_SHIFT < 3 || MIN_SHIFT + 2 >= ADDR_W) begin : g_bad_shift
      $error("window size out of range for this address width");
   end

   logic [ADDR_W-1:0] mask;

   if (SEL_SIZES) begin : g_sel
      always_comb begin
         unique case (word[2:1])
            2'd0:    mask = {ADDR_W{1'b1}} << MIN_SHIFT;
            2'd1:    mask = {ADDR_W{1'b1}} << (MIN_SHIFT + 1);
            default: mask = {ADDR_W{1'b1}} << (MIN_SHIFT + 2);
         endcase
      end
   end else begin : g_fixed
      assign mask = {ADDR_W{1'b1}} << MIN_SHIFT;
   end

   assign hit = word[0] & ((addr & mask) == (word & mask));
endmodule

// File: rtl/addr_dec_legacy.sv
module addr_dec_legacy
   import addr_dec_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int SEG_N     = 16,
   parameter int SEG_SHIFT = 14
)(
   input  logic [ADDR_W-1:0]   addr,
   input  logic                write,
   input  logic [2*SEG_N-1:0]  seg_attr,
   input  logic [1:0]          route,
   output logic                in_low,
   output tgt_vec_t            tgt,
   output logic                ok
);
   localparam int SEG_IW = (SEG_N > 1) ? $clog2(SEG_N) : 1;
   localparam logic [ADDR_W-1:0] LOW_TOP  = ADDR_W'(32'h0010_0000);
   localparam logic [ADDR_W-1:0] VGA_LO   = ADDR_W'(32'h000A_0000);
   localparam logic [ADDR_W-1:0] VGA_HI   = ADDR_W'(32'h000C_0000);
   localparam logic [ADDR_W-1:0] SEG_BASE = LOW_TOP - ADDR_W'(SEG_N << SEG_SHIFT);

   if (SEG_N < 2 || (SEG_N << SEG_SHIFT) > 32'h0004_0000) begin : g_bad_seg
      $error("segments must lie between the graphics range and 1 MB");
   end

   logic [ADDR_W-1:0] off;
   logic [SEG_IW-1:0] sidx;
   seg_attr_e         attr;

   assign in_low = addr < LOW_TOP;
   assign off    = addr - SEG_BASE;
   assign sidx   = off[SEG_SHIFT +: SEG_IW];
   assign attr   = seg_attr_e'(seg_attr[{sidx, 1'b0} +: 2]);

   always_comb begin
      tgt = '0;
      ok  = 1'b1;
      if (addr >= VGA_LO && addr < VGA_HI) begin
         unique case (leg_route_e'(route))
            LG_PEG:  tgt[T_PEG] = 1'b1;
            LG_GFX:  tgt[T_GFX] = 1'b1;
            default: tgt[T_DSL] = 1'b1;
         endcase
      end else if (addr >= SEG_BASE) begin
         unique case (attr)
            SEG_OFF: tgt[T_DSL] = 1'b1;
            SEG_RW:  tgt[T_DRAM] = 1'b1;
            SEG_WO: begin
               tgt[T_DRAM] = write;
               tgt[T_ABT]  = !write;
               ok          = write;
            end
            default: begin
               tgt[T_DRAM] = !write;
               tgt[T_ABT]  = write;
               ok          = !write;
            end
         endcase
      end else begin
         tgt[T_DRAM] = 1'b1;
      end
   end

   logic lg_unused;
   assign lg_unused = ^{off[ADDR_W-1:SEG_SHIFT+SEG_IW], off[SEG_SHIFT-1:0]};
endmodule

// File: rtl/sys_addr_decoder.sv
module sys_addr_decoder
   import addr_dec_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int IDX_W      = 4,
   parameter int SEG_N      = 16,
   parameter int SEG_SHIFT  = 14,
   parameter int GFX_MAX_MB = 64
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [IDX_W-1:0]   cfg_idx,
   input  logic [ADDR_W-1:0]  cfg_wdata,
   input  logic               req_valid,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [1:0]         req_hi,
   input  logic               req_write,
   output logic [TGT_N-1:0]   tgt_sel,
   output logic               perm_ok,
   output logic               unsupported
);
   localparam int MB_W = ADDR_W - 20;

   if (ADDR_W != 32) begin : g_bad_aw
      $error("decoder covers a 4 GB space only");
   end
   if (MB_W < GFX_FW) begin : g_bad_mb
      $error("limit field narrower than carve-out field");
   end

   function automatic int win_shift(int w);
      case (w)
         REG_IREG: return 14;
         REG_EGR:  return 12;
         REG_LREG: return 12;
         default:  return 26;
      endcase
   endfunction

   logic [WIN_N-1:0][ADDR_W-1:0] win_words;
   logic [MB_W-1:0]              limit_mb;
   logic [GFX_FW-1:0]            gfx_mb;
   logic [1:0]                   route;
   logic [2*SEG_N-1:0]           seg_attr;

   addr_dec_cfg #(
      .ADDR_W(ADDR_W), .IDX_W(IDX_W), .SEG_N(SEG_N),
      .GFX_MAX_MB(GFX_MAX_MB), .MB_W(MB_W)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx), .wdata(cfg_wdata),
      .win_words(win_words), .limit_mb(limit_mb), .gfx_mb(gfx_mb),
      .route(route), .seg_attr(seg_attr)
   );

   logic [WIN_N-1:0] win_hit;

   for (genvar w = 0; w < WIN_N; w++) begin : g_win
      addr_dec_win #(
         .ADDR_W(ADDR_W), .MIN_SHIFT(win_shift(w)), .SEL_SIZES(w == REG_CFGW)
      ) u_win (
         .addr(req_addr), .word(win_words[w]), .hit(win_hit[w])
      );
   end

   logic     leg_low;
   tgt_vec_t leg_tgt;
   logic     leg_ok;

   addr_dec_legacy #(
      .ADDR_W(ADDR_W), .SEG_N(SEG_N), .SEG_SHIFT(SEG_SHIFT)
   ) u_leg (
      .addr(req_addr), .write(req_write), .seg_attr(seg_attr), .route(route),
      .in_low(leg_low), .tgt(leg_tgt), .ok(leg_ok)
   );

   logic [MB_W-1:0] gfx_ext;
   logic [MB_W-1:0] carve_mb;
   logic [MB_W-1:0] addr_mb;

   assign gfx_ext  = MB_W'(gfx_mb);
   assign carve_mb = (limit_mb > gfx_ext) ? (limit_mb - gfx_ext) : '0;
   assign addr_mb  = req_addr[ADDR_W-1:20];

   always_comb begin
      logic taken;
      taken       = 1'b0;
      tgt_sel     = '0;
      perm_ok     = 1'b0;
      unsupported = 1'b0;
      if (req_valid) begin
         if (req_hi != 2'b00) begin
            tgt_sel[T_ABT] = 1'b1;
            unsupported    = 1'b1;
         end else if (|win_hit) begin
            for (int w = 0; w < WIN_N; w++) begin
               if (win_hit[w] && !taken) begin
                  tgt_sel[T_IREG + w] = 1'b1;
                  taken = 1'b1;
               end
            end
            perm_ok = 1'b1;
         end else if (leg_low) begin
            tgt_sel = leg_tgt;
            perm_ok = leg_ok;
         end else if (addr_mb >= limit_mb) begin
            tgt_sel[T_DSL] = 1'b1;
            perm_ok        = 1'b1;
         end else if (addr_mb >= carve_mb) begin
            tgt_sel[T_GFX] = 1'b1;
            perm_ok        = 1'b1;
         end else begin
            tgt_sel[T_DRAM] = 1'b1;
            perm_ok         = 1'b1;
         end
      end
   end
endmodule

// File: rtl/addr_dec_check.sv
module addr_dec_check
   import addr_dec_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int MB_W   = 12
)(
   input logic               clk,
   input logic               rst_n,
   input logic               cfg_we,
   input logic               req_valid,
   input logic [ADDR_W-1:0]  req_addr,
   input logic [1:0]         req_hi,
   input logic [TGT_N-1:0]   tgt_sel,
   input logic               perm_ok,
   input logic               unsupported,
   input logic [MB_W-1:0]    limit_mb
);
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> (tgt_sel == '0 && !perm_ok && !unsupported)); // R2
   AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> ($countones(tgt_sel) == 1)); // R2
   AST_ABOVE_4G: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_hi != 2'b00) |-> (tgt_sel[T_ABT] && unsupported && !perm_ok)); // R1
   AST_UNSUP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      unsupported |-> (req_hi != 2'b00)); // R1
   AST_ABORT_DENIED: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_sel[T_ABT] |-> !perm_ok); // R6
   AST_NO_DRAM_ABOVE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_sel[T_DRAM] |-> (req_addr[ADDR_W-1:20] < limit_mb || req_addr < ADDR_W'(32'h0010_0000))); // R9
   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> $stable(limit_mb)); // R12
endmodule

bind sys_addr_decoder addr_dec_check #(.ADDR_W(ADDR_W), .MB_W(MB_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .req_valid(req_valid),
   .req_addr(req_addr), .req_hi(req_hi), .tgt_sel(tgt_sel), .perm_ok(perm_ok),
   .unsupported(unsupported), .limit_mb(limit_mb)
);

// File: tb/tb_sys_addr_decoder.sv
`timescale 1ns/1ps
module tb_sys_addr_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_idx = '0;
   logic [31:0] cfg_wdata = '0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic [1:0]  req_hi = '0;
   logic        req_write = 1'b0;
   logic [8:0]  tgt_sel;
   logic        perm_ok;
   logic        unsupported;

   int    checks = 0;
   int    errors = 0;
   bit    mon_on = 1'b0;
   bit    done = 1'b0;
   string cur_tag = "R2";
   logic [31:0] sh [8];

   always #4 clk = ~clk;

   sys_addr_decoder dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
      .req_valid(req_valid), .req_addr(req_addr), .req_hi(req_hi), .req_write(req_write),
      .tgt_sel(tgt_sel), .perm_ok(perm_ok), .unsupported(unsupported)
   );

   // shadow configuration, words 0..7 only (R12)
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 8; i++) sh[i] <= '0;
      end else if (cfg_we && cfg_idx < 4'd8) begin
         sh[cfg_idx[2:0]] <= cfg_wdata;
      end
   end

   function automatic void ref_dec(input logic [31:0] a, input logic [1:0] hi, input logic wr,
                                   output logic [8:0] s, output logic ok, output logic un);
      longint ua, lo, span;
      int tol, g, st, m, k, at, rt;
      ua = longint'(a);
      s = '0; ok = 1'b0; un = 1'b0;
      if (hi != 2'b00) begin s[8] = 1'b1; un = 1'b1; return; end
      for (int w = 0; w < 4; w++) begin
         case (w)
            0: span = 64'h4000;
            1, 2: span = 64'h1000;
            default: span = (sh[3][2:1] == 2'd0) ? 64'h400_0000 :
                            (sh[3][2:1] == 2'd1) ? 64'h800_0000 : 64'h1000_0000;
         endcase
         lo = longint'(sh[w]) / span * span;
         if (sh[w][0] && ua >= lo && ua < lo + span) begin
            s[w] = 1'b1; ok = 1'b1; return;
         end
      end
      if (ua < 64'h10_0000) begin
         ok = 1'b1;
         if (ua >= 64'hA_0000 && ua < 64'hC_0000) begin
            rt = int'(sh[6][1:0]);
            if (rt == 0) s[6] = 1'b1;
            else if (rt == 2) s[5] = 1'b1;
            else s[7] = 1'b1;
         end else if (ua >= 64'hC_0000) begin
            k  = int'((ua - 64'hC_0000) / 64'h4000);
            at = int'(sh[7][2*k +: 2]);
            if (at == 0) s[7] = 1'b1;
            else if (at == 1) s[4] = 1'b1;
            else if ((at == 2 && wr) || (at == 3 && !wr)) s[4] = 1'b1;
            else begin s[8] = 1'b1; ok = 1'b0; end
         end else begin
            s[4] = 1'b1;
         end
         return;
      end
      tol = int'(sh[4] >> 20);
      g   = int'(sh[5][6:0]);
      if (g > 64) g = 64;
      st  = (tol > g) ? tol - g : 0;
      m   = int'(ua >> 20);
      ok  = 1'b1;
      if (m >= tol) s[7] = 1'b1;
      else if (m >= st) s[5] = 1'b1;
      else s[4] = 1'b1;
   endfunction

   always @(negedge clk) begin
      logic [8:0] es;
      logic eo, eu;
      if (mon_on && !done) begin
         ref_dec(req_addr, req_hi, req_write, es, eo, eu);
         if (!rst_n || !req_valid) begin es = '0; eo = 1'b0; eu = 1'b0; end
         checks++;
         if (tgt_sel !== es || perm_ok !== eo || unsupported !== eu) begin
            errors++;
            $display("FAIL %s addr=%h hi=%0d wr=%0b actual sel=%h ok=%0b un=%0b expected sel=%h ok=%0b un=%0b",
                     cur_tag, req_addr, req_hi, req_write, tgt_sel, perm_ok, unsupported, es, eo, eu);
         end
      end
   end

   task automatic cfg(input logic [3:0] i, input logic [31:0] d);
      @(posedge clk); #1;
      cfg_we = 1'b1; cfg_idx = i; cfg_wdata = d;
      @(posedge clk); #1;
      cfg_we = 1'b0;
   endtask

   task automatic rq(input logic [31:0] a, input logic [1:0] h, input logic w, input string tag);
      @(posedge clk); #1;
      req_valid = 1'b1; req_addr = a; req_hi = h; req_write = w; cur_tag = tag;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R2 watchdog actual=running expected=finished");
         finish_run();
      end
   end

   initial begin
      @(negedge clk);
      mon_on = 1'b1;
      cur_tag = "R2";
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      // reset configuration
      rq(32'h1000_0000, 2'd0, 1'b0, "R9");
      rq(32'hFED1_4000, 2'd0, 1'b0, "R3");
      rq(32'h000A_0000, 2'd0, 1'b0, "R8");
      rq(32'h000C_0000, 2'd0, 1'b1, "R7");
      // program while a request stays asserted (R12)
      rq(32'h1F90_0000, 2'd0, 1'b0, "R12");
      cfg(4'd4, 32'h2000_0000);
      cfg(4'd5, 32'd8);
      cfg(4'd0, 32'hFED1_4001);
      cfg(4'd1, 32'hFED1_9001);
      cfg(4'd2, 32'hFED1_8001);
      cfg(4'd3, 32'hE000_0001);
      cfg(4'd6, 32'd2);
      cfg(4'd7, 32'h0000_00E4);
      rq(32'hFED1_4000, 2'd0, 1'b0, "R3");
      rq(32'hFED1_7FFC, 2'd1 - 2'd1, 1'b1, "R3");
      rq(32'hFED1_8FFF, 2'd0, 1'b0, "R3");
      rq(32'hFED1_9000, 2'd0, 1'b1, "R3");
      rq(32'hFED1_A000, 2'd0, 1'b0, "R9");
      rq(32'hE3FF_FFFF, 2'd0, 1'b0, "R4");
      rq(32'hE400_0000, 2'd0, 1'b0, "R4");
      rq(32'h000C_0000, 2'd0, 1'b0, "R7");
      rq(32'h000C_4000, 2'd0, 1'b1, "R6");
      rq(32'h000C_8000, 2'd0, 1'b0, "R6");
      rq(32'h000C_8000, 2'd0, 1'b1, "R6");
      rq(32'h000C_C000, 2'd0, 1'b0, "R6");
      rq(32'h000C_FFFF, 2'd0, 1'b1, "R6");
      rq(32'h000D_0000, 2'd0, 1'b1, "R7");
      rq(32'h0009_FFFF, 2'd0, 1'b0, "R11");
      rq(32'h0000_0000, 2'd0, 1'b1, "R11");
      rq(32'h000B_FFFF, 2'd0, 1'b0, "R8");
      cfg(4'd6, 32'd1); rq(32'h000A_0000, 2'd0, 1'b0, "R8");
      cfg(4'd6, 32'd3); rq(32'h000A_8000, 2'd0, 1'b1, "R8");
      cfg(4'd6, 32'd0); rq(32'h000B_0000, 2'd0, 1'b0, "R8");
      rq(32'h1FFF_FFFF, 2'd0, 1'b0, "R10");
      rq(32'h1F80_0000, 2'd0, 1'b0, "R10");
      rq(32'h1F7F_FFFF, 2'd0, 1'b0, "R11");
      rq(32'h2000_0000, 2'd0, 1'b1, "R9");
      cfg(4'd5, 32'd100);
      rq(32'h1C00_0000, 2'd0, 1'b0, "R10");
      rq(32'h1BFF_FFFF, 2'd0, 1'b0, "R10");
      cfg(4'd4, 32'h0200_0000); cfg(4'd5, 32'd64);
      rq(32'h0010_0000, 2'd0, 1'b0, "R10");
      rq(32'h0000_0000, 2'd1, 1'b0, "R1");
      rq(32'hFED1_4000, 2'd2, 1'b1, "R1");
      rq(32'h000C_4000, 2'd3, 1'b0, "R1");
      // overlapping windows
      cfg(4'd1, 32'hFED1_4001);
      rq(32'hFED1_4000, 2'd0, 1'b0, "R5");
      cfg(4'd3, 32'hF000_0005);
      rq(32'hFED1_5000, 2'd0, 1'b0, "R5");
      cfg(4'd0, 32'h0);
      rq(32'hFED1_4000, 2'd0, 1'b0, "R5");
      rq(32'hFED1_8000, 2'd0, 1'b0, "R5");
      cfg(4'd1, 32'h0);
      rq(32'hFED1_4000, 2'd0, 1'b0, "R5");
      cfg(4'd3, 32'hE400_0003);
      rq(32'hE000_0000, 2'd0, 1'b0, "R4");
      rq(32'hE7FF_FFFF, 2'd0, 1'b0, "R4");
      rq(32'hE800_0000, 2'd0, 1'b0, "R4");
      cfg(4'd3, 32'hE000_0007);
      rq(32'hEFFF_FFFF, 2'd0, 1'b0, "R4");
      // ignored indices
      cfg(4'd9, 32'hFFFF_FFFF);
      cfg(4'd15, 32'h0000_0001);
      rq(32'hE000_0000, 2'd0, 1'b0, "R12");
      rq(32'h000C_0000, 2'd0, 1'b0, "R12");
      @(posedge clk); #1 req_valid = 1'b0; cur_tag = "R2";
      @(posedge clk);
      // random phase: configuration writes collide with requests
      for (int n = 0; n < 6000; n++) begin
         @(posedge clk); #1;
         cur_tag = "R12";
         req_valid = ($urandom_range(0, 7) != 0);
         case ($urandom_range(0, 5))
            0: req_addr = $urandom_range(0, 32'h000F_FFFF);
            1: req_addr = 32'hFED0_0000 | $urandom_range(0, 32'h000F_FFFF);
            2: req_addr = {sh[4][31:20] - 12'($urandom_range(0, 70)), 20'($urandom)};
            3: req_addr = 32'hE000_0000 | ($urandom & 32'h1FFF_FFFF);
            default: req_addr = $urandom;
         endcase
         req_hi    = ($urandom_range(0, 9) == 0) ? 2'($urandom_range(1, 3)) : 2'd0;
         req_write = 1'($urandom);
         cfg_we    = ($urandom_range(0, 5) == 0);
         cfg_idx   = 4'($urandom);
         case (cfg_idx)
            4'd0, 4'd1, 4'd2: cfg_wdata = 32'hFED0_0000 | ($urandom & 32'h000F_F001);
            4'd3: cfg_wdata = 32'hE000_0000 | ($urandom & 32'h1C00_0007);
            4'd4: cfg_wdata = {12'($urandom_range(0, 4095)), 20'($urandom)};
            4'd5: cfg_wdata = 32'($urandom_range(0, 127));
            default: cfg_wdata = $urandom;
         endcase
      end
      @(posedge clk); #1 cfg_we = 1'b0; req_valid = 1'b0; cur_tag = "R2";
      repeat (2) @(posedge clk);
      @(negedge clk);
      #1 finish_run();
   end
endmodule